// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Preamble and Break

This block converts data words into asynchronous serial frames on a single transmit line. Software writes an 8- or 9-bit word into a one-entry holding register. At the next bit boundary the word moves into a shift register and goes out least significant bit first, framed by a low start bit and a high stop bit. An external pulse, one clock wide and one bit time apart, sets the pace of every bit. Two flags tell software when the holding register can take another word and when the line has gone quiet. A maskable request follows the holding-register flag.

When the enable goes from 0 to 1, the block sends a synchronising all-ones character of frame length before any data. Dropping the enable and raising it again during a frame queues such a character behind that frame. While break is requested, the block sends all-zeros characters back to back. Once the request is dropped, it finishes the current one and holds the line high for at least one bit before the next frame. When the block is disabled, it completes the frame on the line and then gives the pin to a general-purpose port bit and its direction control. A word still waiting in the holding register is not sent.

Top module: `serial_tx`

## Requirements
- R1: A data frame is a 0 start bit, then the data bits least significant first (8 bits when len9=0, 9 bits when len9=1), then a 1 stop bit. Each bit lasts from one bit_tick to the next, and the line changes only at the clock edge that samples a bit_tick.
- R2: While tx_en=1 and nothing is shifting, txd=1 and txd_oe=1.
- R3: Each 0-to-1 change of tx_en queues a preamble of all ones with no start or stop bit, 10 bits long (len9=0) or 11 bits long (len9=1). The preamble goes out before any data frame.
- R4: If tx_en is cleared and set again while a frame is shifting, a full all-ones character follows that frame before the next data frame starts.
- R5: A write (wr_en=1) clears hold_empty. hold_empty returns to 1 when the word moves into the shift register. A second write while hold_empty=0 replaces the waiting word, and only the newer word is sent.
- R6: irq is 1 exactly when hold_empty=1 and irq_en=1.
- R7: line_done is 0 while a character is shifting or while data, a preamble or a break is waiting. It is 1 once the line is quiet with nothing pending.
- R8: While brk_req=1 and tx_en=1, all-zeros characters of 10 or 11 bits (by len9) are sent back to back with no high bit between them.
- R9: After brk_req is cleared, the break character in progress completes, then at least one 1 bit is sent before the next frame.
- R10: Clearing tx_en during a frame lets that frame finish. After that the block stops driving, and a word waiting in the holding register stays unsent (hold_empty stays 0) until the block is enabled again.
- R11: When the block is disabled and idle, txd_oe equals gp_dir and, while gp_dir=1, txd equals gp_out.
- R12: At a character boundary a break goes before a queued preamble, and a queued preamble goes before waiting data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter enable |
| len9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| brk_req | input | 1 | Hold high to stream break characters |
| irq_en | input | 1 | Request mask for hold_empty |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW+1 | Word to send (top bit used only with len9=1) |
| gp_out | input | 1 | Port data bit used when the pin is released |
| gp_dir | input | 1 | Port direction, 1 drives the pin when released |
| txd | output | 1 | Serial line value |
| txd_oe | output | 1 | Output enable for the serial pin |
| hold_empty | output | 1 | Holding register can accept a word |
| line_done | output | 1 | Line quiet with nothing pending |
| irq | output | 1 | Masked request for hold_empty |

## Verification
The bench targets the preamble length after an enable edge. A design that skipped it, or made it one bit too short or too long, would move the start bit of the first frame. It also checks that an enable dropped and raised mid-frame inserts a full idle character between two frames that would otherwise run back to back. A break run that ran straight into the next start bit, without the trailing high bit, would leave a zero run that is not a whole number of break characters. A disable that dropped the frame in progress, or that still sent the waiting word, would show up as a broken frame or a hold_empty flag that sets while the block is off.

// File: rtl/serial_tx.sv
`timescale 1ns/1ps
module serial_tx #(
  parameter int DW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        tx_en,
  input  logic        len9,
  input  logic        brk_req,
  input  logic        irq_en,
  input  logic        wr_en,
  input  logic [DW:0] wr_data,
  input  logic        gp_out,
  input  logic        gp_dir,
  output logic        txd,
  output logic        txd_oe,
  output logic        hold_empty,
  output logic        line_done,
  output logic        irq
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW + 1);
  localparam logic [1:0] K_DATA = 2'd0;
  localparam logic [1:0] K_IDLE = 2'd1;
  localparam logic [1:0] K_BRK  = 2'd2;

  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [1:0]    kind;
  logic          busy, en_q, pre_pend, pend_v;
  logic [DW:0]   pend_d;
  logic [FW-1:0] dat_frame;

  wire rise   = tx_en & ~en_q;
  wire pre_q  = pre_pend | rise;
  wire last   = busy && (cnt == CW'(1));
  wire slot   = bit_tick && (!busy || last);
  wire gap    = last && (kind == K_BRK) && !brk_req;
  wire go     = slot && tx_en && !gap;
  wire ld_brk = go && brk_req;
  wire ld_pre = go && !brk_req && pre_q;
  wire ld_dat = go && !brk_req && !pre_q && pend_v;
  wire ld     = ld_brk | ld_pre | ld_dat;
  wire [CW-1:0] len = len9 ? CW'(FW) : CW'(FW - 1);

  always_comb begin
    if (len9) dat_frame = {1'b1, pend_d, 1'b0};
    else      dat_frame = {2'b11, pend_d[DW-1:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '1;
      cnt      <= '0;
      kind     <= K_IDLE;
      busy     <= 1'b0;
      en_q     <= 1'b0;
      pre_pend <= 1'b0;
      pend_v   <= 1'b0;
      pend_d   <= '0;
    end else begin
      en_q <= tx_en;
      if (ld_pre)    pre_pend <= 1'b0;
      else if (rise) pre_pend <= 1'b1;
      if (wr_en) begin
        pend_v <= 1'b1;
        pend_d <= wr_data;
      end else if (ld_dat) begin
        pend_v <= 1'b0;
      end
      if (ld) begin
        busy <= 1'b1;
        cnt  <= len;
        kind <= ld_brk ? K_BRK : (ld_pre ? K_IDLE : K_DATA);
        sh   <= ld_brk ? '0 : (ld_pre ? '1 : dat_frame);
      end else if (busy && bit_tick) begin
        if (last) busy <= 1'b0;
        cnt <= cnt - CW'(1);
        sh  <= {1'b1, sh[FW-1:1]};
      end
    end
  end

  wire own = tx_en | busy;
  assign txd        = own ? (busy ? sh[0] : 1'b1) : gp_out;
  assign txd_oe     = own | gp_dir;
  assign hold_empty = ~pend_v;
  assign line_done  = !busy && !pend_v && !pre_q && !(brk_req && tx_en);
  assign irq        = hold_empty & irq_en;
endmodule

// File: rtl/serial_tx_chk.sv
`timescale 1ns/1ps
module serial_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       tx_en,
  input logic       wr_en,
  input logic       gp_out,
  input logic       gp_dir,
  input logic       txd,
  input logic       txd_oe,
  input logic       hold_empty,
  input logic       line_done,
  input logic       busy,
  input logic [1:0] kind
);
  p_bit_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> (busy && $stable(txd)));

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !busy) |-> (txd && txd_oe));

  p_hold_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty);

  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !line_done);

  p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == 2'd2) |-> !txd);

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |-> (txd_oe == gp_dir && (!gp_dir || txd == gp_out)));
endmodule

bind serial_tx serial_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
  .wr_en(wr_en), .gp_out(gp_out), .gp_dir(gp_dir), .txd(txd),
  .txd_oe(txd_oe), .hold_empty(hold_empty), .line_done(line_done),
  .busy(busy), .kind(kind)
);

// File: tb/sim_serial_tx.sv
`timescale 1ns/1ps
module sim_serial_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, len9 = 0, brk_req = 0, irq_en = 0, wr_en = 0;
  logic gp_out = 0, gp_dir = 0;
  logic [8:0] wr_data = '0;
  logic txd, txd_oe, hold_empty, line_done, irq;
  logic [1:0] tcnt = 2'd0;
  wire bit_tick = (tcnt == 2'd3);
  int nchk = 0, nbad = 0;
  logic lg [0:4095];
  int ln = 0;

  always #4 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 2'd1;
  always @(negedge clk) if (rst_n && bit_tick && ln < 4096) begin lg[ln] = txd; ln = ln + 1; end

  serial_tx u0 (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .len9(len9),
    .brk_req(brk_req), .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .gp_out(gp_out),
    .gp_dir(gp_dir), .txd(txd), .txd_oe(txd_oe), .hold_empty(hold_empty),
    .line_done(line_done), .irq(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin nbad++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  function automatic int fz(input int from);
    for (int i = from; i < ln; i++) if (lg[i] == 1'b0) return i;
    return ln;
  endfunction

  function automatic int fo(input int from);
    for (int i = from; i < ln; i++) if (lg[i] == 1'b1) return i;
    return ln;
  endfunction

  function automatic int word(input int s, input bit m);
    int w = 0;
    for (int i = 0; i < (m ? 9 : 8); i++) if (s + 1 + i < ln && lg[s + 1 + i]) w |= (1 << i);
    return w;
  endfunction

  task automatic tk(input int n);
    repeat (n * 4) @(negedge clk);
    #1;
  endtask

  task automatic align();
    @(negedge clk);
    while (bit_tick !== 1'b1) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [8:0] d);
    @(negedge clk); #1;
    wr_data = d; wr_en = 1;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic t_reset();
    chk(hold_empty == 1, "R5 reset hold_empty", hold_empty, 1);
    chk(line_done == 1, "R7 reset line_done", line_done, 1);
    chk(txd_oe == 0, "R11 reset txd_oe", txd_oe, 0);
    chk(irq == 0, "R6 reset irq masked", irq, 0);
    gp_dir = 1; gp_out = 1; #1;
    chk(txd == 1 && txd_oe == 1, "R11 released pin drives port", txd, 1);
    gp_dir = 0; gp_out = 0;
  endtask

  task automatic t_preamble();
    int s;
    irq_en = 1;
    align(); ln = 0;
    tx_en = 1; wr_data = 9'h011; wr_en = 1;
    @(negedge clk); #1; wr_data = 9'h0A5;
    @(negedge clk); #1; wr_en = 0;
    chk(hold_empty == 0, "R5 write clears hold_empty", hold_empty, 0);
    chk(irq == 0, "R6 irq low when full", irq, 0);
    tk(3);
    chk(line_done == 0, "R7 busy during preamble", line_done, 0);
    chk(hold_empty == 0, "R12 data waits behind preamble", hold_empty, 0);
    tk(30);
    s = fz(0);
    chk(s == 10, "R3 preamble length", s, 10);
    chk(word(s, 0) == 'hA5, "R5 overwrite keeps newer word", word(s, 0), 'hA5);
    chk(lg[s + 9] == 1, "R1 stop bit", lg[s + 9], 1);
    chk(hold_empty == 1 && line_done == 1, "R7 quiet after frame", line_done, 1);
    chk(irq == 1, "R6 irq with empty and enabled", irq, 1);
    irq_en = 0; #1;
    chk(irq == 0, "R6 irq masked", irq, 0);
    chk(txd == 1 && txd_oe == 1, "R2 idle line high", txd, 1);
  endtask

  task automatic t_nine();
    int s1, s2, to;
    len9 = 1;
    align(); ln = 0;
    wr(9'h1C3);
    to = 0;
    while (hold_empty !== 1'b1 && to < 400) begin @(negedge clk); to++; end
    #1;
    wr(9'h0F0);
    tk(40);
    s1 = fz(0);
    chk(word(s1, 1) == 'h1C3, "R1 nine-bit word", word(s1, 1), 'h1C3);
    chk(lg[s1 + 10] == 1, "R1 nine-bit stop", lg[s1 + 10], 1);
    s2 = fz(s1 + 11);
    chk(s2 == s1 + 11, "R1 frames back to back", s2 - s1, 11);
    chk(word(s2, 1) == 'h0F0, "R1 second nine-bit word", word(s2, 1), 'h0F0);
    len9 = 0;
  endtask

  task automatic t_break();
    int z, s;
    align(); ln = 0;
    brk_req = 1; wr_data = 9'h05A; wr_en = 1;
    @(negedge clk); #1; wr_en = 0;
    tk(5);
    chk(line_done == 0, "R7 busy during break", line_done, 0);
    tk(20);
    chk(hold_empty == 0, "R12 break before data", hold_empty, 0);
    brk_req = 0;
    tk(25);
    z = fo(0);
    chk(z == 30, "R8 three whole break characters", z, 30);
    s = fz(z);
    chk(s > z && s == 31, "R9 mark bit after break", s - z, 1);
    chk(word(s, 0) == 'h5A, "R9 frame after break", word(s, 0), 'h5A);
  endtask

  task automatic t_disable();
    int s;
    gp_dir = 1; gp_out = 0;
    align(); ln = 0;
    wr_data = 9'h03C; wr_en = 1;
    @(negedge clk); #1; wr_en = 0;
    tk(3);
    chk(line_done == 0, "R7 busy in frame", line_done, 0);
    tx_en = 0;
    wr(9'h0C3);
    chk(txd_oe == 1 && txd !== 1'bx, "R10 still driving mid frame", txd_oe, 1);
    tk(12);
    s = fz(0);
    chk(word(s, 0) == 'h3C, "R10 frame completes", word(s, 0), 'h3C);
    chk(lg[s + 9] == 1, "R10 stop bit sent", lg[s + 9], 1);
    chk(txd == 0 && txd_oe == 1, "R11 port value low", txd, 0);
    chk(hold_empty == 0, "R10 waiting word not sent", hold_empty, 0);
    gp_out = 1; #1;
    chk(txd == 1, "R11 port value high", txd, 1);
    gp_dir = 0; #1;
    chk(txd_oe == 0, "R11 released pin floats", txd_oe, 0);
    align(); ln = 0;
    tx_en = 1;
    tk(25);
    s = fz(0);
    chk(s == 10, "R3 preamble after re-enable", s, 10);
    chk(word(s, 0) == 'hC3, "R12 kept word after preamble", word(s, 0), 'hC3);
    chk(hold_empty == 1, "R5 moved to shifter", hold_empty, 1);
  endtask

  task automatic t_toggle();
    int s1, s2;
    align(); ln = 0;
    wr_data = 9'h081; wr_en = 1;
    @(negedge clk); #1; wr_en = 0;
    tk(4);
    tx_en = 0;
    @(negedge clk); #1; tx_en = 1;
    wr(9'h07E);
    tk(40);
    s1 = fz(0);
    chk(word(s1, 0) == 'h81, "R4 first frame", word(s1, 0), 'h81);
    s2 = fz(s1 + 10);
    chk(s2 - s1 == 20, "R4 idle character between frames", s2 - s1, 20);
    chk(word(s2, 0) == 'h7E, "R4 second frame", word(s2, 0), 'h7E);
  endtask

  initial begin
    #1200000;
    nchk++; nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_preamble();
    t_nine();
    t_break();
    t_disable();
    t_toggle();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule